// File: doc/BRIEF.md
# SIMD Byte-Immediate Logic Unit

This block is a one-cycle execution slice for a 128-bit vector datapath. It takes an 8-bit immediate from the instruction word and combines it with every byte lane of a source vector. The plain logic operations are AND, OR, XOR and NOR. Three further bit-move operations also read the current value of the destination register as a third operand. The result goes back to the register file together with a write strobe and the destination index.

The decoder supplies an operation code, the raw instruction word, the source vector and the destination's present contents, all in one cycle with a valid strobe. The block decodes the immediate and the two register indices from fixed fields of the word. The source index is presented at once so the register file can read it. The result, the write strobe and the destination index appear on the following clock.

A 32-bit register-modified mask is kept here. When write tracking is enabled, each completed operation sets the mask bit that matches its destination index. An unused operation code raises an illegal-operation flag instead of writing.

Top module: `simd_byte_imm_alu`

## Requirements
- R1: A synchronous active-low reset clears the write strobe, the illegal flag, the result and the modified mask. All of them read zero on the first sampling after reset is released.
- R2: Op codes 0 (AND), 1 (OR) and 3 (XOR) give each result byte as the source byte combined with the 8-bit immediate. The same immediate is used unchanged in all sixteen lanes.
- R3: Op code 2 (NOR) gives each result byte as the bitwise complement of (source byte OR immediate).
- R4: Op code 4 (move where set) takes a result bit from the source where the immediate bit is 1. Where the immediate bit is 0, it keeps the old destination bit.
- R5: Op code 5 (move where clear) takes a result bit from the source where the immediate bit is 0. Where the immediate bit is 1, it keeps the old destination bit.
- R6: Op code 6 (select) takes a result bit from the immediate where the old destination bit is 1. Where the old destination bit is 0, it takes the source bit.
- R7: The immediate is read from instruction bits [23:16], the source index from bits [15:11] and the destination index from bits [10:6]. All other instruction bits have no effect. `src_idx` follows bits [15:11] with no clock delay.
- R8: For a valid legal operation, `res_vec`, `wr_idx` and a high `wr_en` appear one clock after `in_valid`. Without `in_valid`, `wr_en` is low on the following clock.
- R9: Op code 7 with `in_valid` raises `illegal_op` for one clock after the strobe. In that case `wr_en` stays low and the modified mask is unchanged.
- R10: A completed legal operation with `track_en` high sets mask bit `wr_idx` on the same clock that `wr_en` rises, and keeps every other bit. With `track_en` low, the mask is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_sel | input | 3 | Operation code (0..6 legal, 7 illegal) |
| insn | input | 32 | Instruction word holding immediate and register indices |
| track_en | input | 1 | Write-tracking enable for the modified mask |
| src_vec | input | 128 | Source vector contents |
| old_dst_vec | input | 128 | Current destination vector contents |
| src_idx | output | 5 | Source register index for the register-file read |
| res_vec | output | 128 | Registered result vector |
| wr_en | output | 1 | Registered destination write strobe |
| wr_idx | output | 5 | Registered destination index |
| illegal_op | output | 1 | Registered illegal-operation flag |
| mod_mask | output | 32 | Register-modified mask |

## Verification
A new operation can be accepted on the same clock that the previous one's result, write strobe and mask update leave the block. The mask can also be set twice in a row, either for the same register or for different ones. The bench provokes this with back-to-back strobes: legal operations on different and equal destinations, a legal operation followed directly by an illegal code, and a change of `track_en` between neighbours. On every clock, a behavioural model predicts the outputs from the strobe one cycle earlier, and the bench compares them. A mix-up of pipeline stages or a mask OR that drops an earlier bit therefore shows up as a mismatch.

// File: rtl/sbil_pkg.sv
// Shared constants and types for the byte-immediate logic unit.
// Assumes an 8-bit immediate applied to 8-bit lanes and 5-bit register indices.
package sbil_pkg;
    localparam int unsigned LANE_W  = 8;
    localparam int unsigned IDX_W   = 5;
    localparam int unsigned NREGS   = 1 << IDX_W;
    localparam int unsigned INSN_W  = 32;
    localparam int unsigned IMM_LSB = 16;
    localparam int unsigned SRC_LSB = 11;
    localparam int unsigned DST_LSB = 6;

    typedef enum logic [2:0] {
        OP_AND    = 3'd0,
        OP_OR     = 3'd1,
        OP_NOR    = 3'd2,
        OP_XOR    = 3'd3,
        OP_MOVSET = 3'd4,
        OP_MOVCLR = 3'd5,
        OP_SEL    = 3'd6,
        OP_BAD    = 3'd7
    } op_e;

    typedef struct packed {
        logic [LANE_W-1:0] imm;
        logic [IDX_W-1:0]  src;
        logic [IDX_W-1:0]  dst;
    } fields_t;
endpackage

// File: rtl/sbil_decode.sv
// Field extraction and operation legality.
// Assumes fixed field positions from sbil_pkg; bits outside the fields are ignored.
module sbil_decode
    import sbil_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic [2:0]        op_sel,
    output fields_t           fields,
    output op_e               op,
    output logic              legal
);
    logic unused_insn_bits;

    // Pull the immediate and register indices out of the instruction word.
    always_comb begin
        fields.imm = insn[IMM_LSB +: LANE_W];
        fields.src = insn[SRC_LSB +: IDX_W];
        fields.dst = insn[DST_LSB +: IDX_W];
    end

    // Classify the operation code.
    always_comb begin
        op    = op_e'(op_sel);
        legal = (op != OP_BAD);
    end

    assign unused_insn_bits = ^{insn[INSN_W-1:IMM_LSB+LANE_W], insn[DST_LSB-1:0]};
endmodule

// File: rtl/sbil_lane.sv
// One byte lane: combines source, old destination and immediate per the op code.
// Purely combinational; an illegal code yields zero (never written anyway).
module sbil_lane
    import sbil_pkg::*;
(
    input  op_e               op,
    input  logic [LANE_W-1:0] s,
    input  logic [LANE_W-1:0] d,
    input  logic [LANE_W-1:0] imm,
    output logic [LANE_W-1:0] y
);
    // Per-lane operation mux.
    always_comb begin
        unique case (op)
            OP_AND:    y = s & imm;
            OP_OR:     y = s | imm;
            OP_NOR:    y = ~(s | imm);
            OP_XOR:    y = s ^ imm;
            OP_MOVSET: y = (d & ~imm) | (s & imm);
            OP_MOVCLR: y = (d & imm) | (s & ~imm);
            OP_SEL:    y = (s & ~d) | (imm & d);
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/sbil_track.sv
// Register-modified mask: ORs in one bit per tracked completion.
// Assumes at most one set request per clock; synchronous active-low reset clears it.
module sbil_track
    import sbil_pkg::*;
#(
    parameter int unsigned N = NREGS,
    localparam int unsigned IW = $clog2(N)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    output logic [N-1:0]  mask
);
    logic [N-1:0] set_vec;

    // Decode the index into a one-hot set vector.
    always_comb begin
        set_vec = '0;
        if (set_en) set_vec[set_idx] = 1'b1;
    end

    // Accumulate set bits.
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else        mask <= mask | set_vec;
    end
endmodule

// File: rtl/simd_byte_imm_alu.sv
// Top: byte-immediate logic unit over a vector of LANE_W-bit lanes.
// Assumes src_vec and old_dst_vec are valid in the cycle of in_valid; results
// leave one clock later. Forwarding of in-flight results is the caller's job.
module simd_byte_imm_alu
    import sbil_pkg::*;
#(
    parameter int unsigned VEC_W = 128,
    localparam int unsigned LANES = VEC_W / LANE_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op_sel,
    input  logic [INSN_W-1:0] insn,
    input  logic              track_en,
    input  logic [VEC_W-1:0]  src_vec,
    input  logic [VEC_W-1:0]  old_dst_vec,
    output logic [IDX_W-1:0]  src_idx,
    output logic [VEC_W-1:0]  res_vec,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              illegal_op,
    output logic [NREGS-1:0]  mod_mask
);
    fields_t           fld;
    op_e               op;
    logic              legal;
    logic [VEC_W-1:0]  lane_out;
    logic              accept;

    sbil_decode u_dec (
        .insn   (insn),
        .op_sel (op_sel),
        .fields (fld),
        .op     (op),
        .legal  (legal)
    );

    // Replicate one lane per byte of the vector.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sbil_lane u_lane (
            .op  (op),
            .s   (src_vec[g*LANE_W +: LANE_W]),
            .d   (old_dst_vec[g*LANE_W +: LANE_W]),
            .imm (fld.imm),
            .y   (lane_out[g*LANE_W +: LANE_W])
        );
    end

    // A legal operation is accepted when strobed.
    assign accept  = in_valid && legal;
    assign src_idx = fld.src;

    // Output stage: result, write strobe, index and illegal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vec    <= '0;
            wr_en      <= 1'b0;
            wr_idx     <= '0;
            illegal_op <= 1'b0;
        end else begin
            wr_en      <= accept;
            illegal_op <= in_valid && !legal;
            if (accept) begin
                res_vec <= lane_out;
                wr_idx  <= fld.dst;
            end
        end
    end

    sbil_track #(.N(NREGS)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (accept && track_en),
        .set_idx (fld.dst),
        .mask    (mod_mask)
    );
endmodule

// File: rtl/sbil_checker.sv
// Temporal checks on the ports of simd_byte_imm_alu, attached by bind.
module sbil_checker
    import sbil_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op_sel,
    input logic [INSN_W-1:0] insn,
    input logic              track_en,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic              illegal_op,
    input logic [NREGS-1:0]  mod_mask
);
    p_write_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel != 3'd7) |=> wr_en);

    p_idle_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wr_en && !illegal_op));

    p_wr_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel != 3'd7) |=> (wr_idx == $past(insn[DST_LSB +: IDX_W])));

    p_illegal_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd7) |=> (illegal_op && !wr_en && $stable(mod_mask)));

    p_mask_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel != 3'd7 && track_en) |=>
        (mod_mask == ($past(mod_mask) | (NREGS'(1) << $past(insn[DST_LSB +: IDX_W])))));

    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && op_sel != 3'd7 && track_en) |=> $stable(mod_mask));

    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && illegal_op));
endmodule

bind simd_byte_imm_alu sbil_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_sel     (op_sel),
    .insn       (insn),
    .track_en   (track_en),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .illegal_op (illegal_op),
    .mod_mask   (mod_mask)
);

// File: tb/sim_simd_byte_imm_alu.sv
// Bench: behavioural per-clock model of the byte-immediate logic unit.
module sim_simd_byte_imm_alu;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   op_sel = 3'd0;
    logic [31:0]  insn = 32'd0;
    logic         track_en = 1'b0;
    logic [127:0] src_vec = '0;
    logic [127:0] old_dst_vec = '0;
    logic [4:0]   src_idx;
    logic [127:0] res_vec;
    logic         wr_en;
    logic [4:0]   wr_idx;
    logic         illegal_op;
    logic [31:0]  mod_mask;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic [127:0] e_res;
    logic         e_wr;
    logic [4:0]   e_idx;
    logic         e_ill;
    logic [31:0]  e_mask;
    string        e_req;

    always #4 clk = ~clk;

    simd_byte_imm_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .insn(insn), .track_en(track_en), .src_vec(src_vec),
        .old_dst_vec(old_dst_vec), .src_idx(src_idx), .res_vec(res_vec),
        .wr_en(wr_en), .wr_idx(wr_idx), .illegal_op(illegal_op),
        .mod_mask(mod_mask)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(input int op);
        case (op)
            0, 1, 3: return "R2";
            2:       return "R3";
            4:       return "R4";
            5:       return "R5";
            6:       return "R6";
            default: return "R9";
        endcase
    endfunction

    // Bit-by-bit model of one operation across all lanes.
    function automatic logic [127:0] model(input int op, input logic [127:0] s,
                                           input logic [127:0] d, input logic [7:0] imm);
        logic [127:0] r = '0;
        for (int b = 0; b < 128; b++) begin
            logic k = imm[b % 8];
            case (op)
                0: r[b] = s[b] && k;
                1: r[b] = s[b] || k;
                2: r[b] = !(s[b] || k);
                3: r[b] = s[b] != k;
                4: r[b] = k ? s[b] : d[b];
                5: r[b] = k ? d[b] : s[b];
                6: r[b] = d[b] ? k : s[b];
                default: r[b] = 1'b0;
            endcase
        end
        return r;
    endfunction

    // One clock: check outputs from the previous strobe, then drive the next.
    task automatic cyc(input bit v, input int op, input logic [7:0] imm,
                       input logic [4:0] ws, input logic [4:0] wd, input bit trk,
                       input logic [127:0] s, input logic [127:0] d);
        @(negedge clk);
        chk("R8 wr_en", {127'd0, wr_en}, {127'd0, e_wr});
        chk("R9 illegal_op", {127'd0, illegal_op}, {127'd0, e_ill});
        chk("R10 mod_mask", {96'd0, mod_mask}, {96'd0, e_mask});
        if (e_wr) begin
            chk({e_req, " res_vec"}, res_vec, e_res);
            chk("R7 wr_idx", {123'd0, wr_idx}, {123'd0, e_idx});
        end
        in_valid = v; op_sel = op[2:0]; track_en = trk;
        insn = {8'hA5, imm, ws, wd, 6'h2B};
        src_vec = s; old_dst_vec = d;
        e_wr  = v && op != 7;
        e_ill = v && op == 7;
        e_req = req_of(op);
        if (e_wr) begin
            e_res = model(op, s, d, imm);
            e_idx = wd;
            if (trk) e_mask = e_mask | (32'd1 << wd);
        end
        #1;
        chk("R7 src_idx", {123'd0, src_idx}, {123'd0, ws});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        e_wr = 0; e_ill = 0; e_mask = '0; e_res = '0; e_idx = '0; e_req = "R1";
        chk("R1 wr_en", {127'd0, wr_en}, 128'd0);
        chk("R1 illegal_op", {127'd0, illegal_op}, 128'd0);
        chk("R1 mod_mask", {96'd0, mod_mask}, 128'd0);
        chk("R1 res_vec", res_vec, 128'd0);
    endtask

    localparam logic [127:0] PA = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    localparam logic [127:0] PB = 128'hF0F0_3C3C_AAAA_5555_0FF0_C3C3_9669_00FF;
    localparam logic [127:0] PC = {16{8'h5A}};

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // Every legal op on several patterns, back to back, tracking on.
        for (int op = 0; op < 7; op++) begin
            cyc(1, op, 8'h3C, 5'(op), 5'(op + 1), 1, PA, PB);
            cyc(1, op, 8'hFF, 5'(op + 2), 5'(op + 9), 1, PB, PC);
            cyc(1, op, 8'h00, 5'(op + 3), 5'(op + 17), 1, PC, PA);
            cyc(1, op, 8'h81, 5'd31, 5'(op + 24), 1, ~PA, PA);
        end
        cyc(0, 0, 8'h00, 5'd0, 5'd0, 0, '0, '0);
        // Boundary indices and repeated set of the same register (R10).
        cyc(1, 4, 8'hA5, 5'd1, 5'd0, 1, PA, PC);
        cyc(1, 5, 8'h5A, 5'd2, 5'd31, 1, PB, PA);
        cyc(1, 6, 8'h0F, 5'd3, 5'd31, 1, PC, PB);
        // Tracking off leaves the mask alone (R10).
        do_reset();
        cyc(1, 3, 8'h77, 5'd4, 5'd12, 0, PA, PB);
        cyc(1, 1, 8'h10, 5'd4, 5'd13, 1, PB, PA);
        // Illegal code right after a legal op, tracking on (R9).
        cyc(1, 7, 8'hFF, 5'd5, 5'd20, 1, PA, PB);
        cyc(1, 7, 8'h01, 5'd6, 5'd21, 1, PB, PA);
        cyc(1, 2, 8'hC3, 5'd7, 5'd20, 1, PC, PC);
        cyc(0, 7, 8'h00, 5'd8, 5'd22, 1, PA, PA);
        cyc(0, 0, 8'h00, 5'd0, 5'd0, 0, '0, '0);
        // Reset clears a populated mask (R1).
        do_reset();
        cyc(0, 0, 8'h00, 5'd9, 5'd0, 0, '0, '0);
        cyc(0, 0, 8'h00, 5'd0, 5'd0, 0, '0, '0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule